// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block sets the feedback divide ratio of a fractional-N synthesizer one divide cycle at a time. Software programs three words: an integer part, a fraction numerator and a modulus. Over a long run the mean divide ratio equals integer + numerator / modulus. A third-order cascaded modulo accumulator produces a small signed offset for each divide cycle. The offset pushes the quantisation error of the fraction up to high frequencies. The modulus is a free value, not a power of two, so the user can choose between a finer step and a lower spur level.

The block runs on the output clock of a dual-modulus prescaler. Each ratio N = integer + offset is split into a main count and a swallow count for the selected prescaler pair, 4/5 or 8/9. A counter pair then drives the prescaler's modulus-select line and emits one pulse when each divide cycle ends. New words pass through a shadow stage and take effect at the next divide-cycle boundary. A ratio that the counter pair cannot realise is flagged.

Top module: `fracn_divctl`

## Requirements
- R1: While reset is held, and until the first load, every output is zero and no divide pulse appears.
- R2: A one-cycle `load` captures the words, which take effect at the next divide-cycle boundary. The cycle in progress keeps its `n_cur`, `b_cur` and `a_cur`, and the noise shaper restarts from a cleared state on the cycle that applies the new words.
- R3: A divide cycle lasts `b_cur` clocks and ends with a single-cycle `div_pulse`. Counting P+1 input periods for each clock with `mod_ctl` high and P for each other clock gives exactly `n_cur`.
- R4: `b_cur` = `n_cur` / P and `a_cur` = `n_cur` mod P. P is 4 when `psel_in` = 0 (4/5 pair) and 8 when `psel_in` = 1 (8/9 pair).
- R5: `mod_ctl` is high for the first `a_cur` clocks of a divide cycle and low for the rest.
- R6: Each cycle's ratio differs from the integer word by -3 to +4.
- R7: Over the 8×modulus divide cycles that follow a load, the summed ratios are within 1 of 8×(modulus×integer + fraction). The accumulators wrap at the programmed modulus, which need not be a power of two.
- R8: With fraction = 0, every divide cycle uses exactly the integer word.
- R9: A ratio that is negative, gives main count < swallow count, or gives a main count above 511 raises `ratio_err`. The counters then load zero and the block idles with no divide pulses. A ratio of 0 idles with `ratio_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | One-cycle strobe that captures the three words and the prescaler select |
| int_in | input | 12 | Integer part of the ratio |
| frac_in | input | 12 | Fraction numerator, below the modulus |
| mod_in | input | 12 | Modulus, 2 or more |
| psel_in | input | 1 | Prescaler pair: 0 = 4/5, 1 = 8/9 |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = divide by P+1 |
| div_pulse | output | 1 | High in the last clock of each divide cycle |
| n_cur | output | 12 | Ratio of the divide cycle in progress |
| b_cur | output | 9 | Main count of the divide cycle in progress |
| a_cur | output | 3 | Swallow count of the divide cycle in progress |
| ratio_err | output | 1 | Current ratio cannot be realised |

## Verification
`mod_ctl` and `div_pulse` come from the counter state of the current clock, so the bench samples them in that same clock. `n_cur`, `b_cur`, `a_cur` and `ratio_err` change on the edge that ends the clock in which `div_pulse` is high. The bench reads them at the first falling edge of the new divide cycle. A load reaches the shadow stage one edge after the strobe and becomes active at the next boundary. While idle, that boundary is the following edge. The bench waits out each of these delays before it compares anything. It measures every cycle's length and swallow prefix directly at the ports.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  typedef enum logic {
    PS_LO = 1'b0,
    PS_HI = 1'b1
  } psel_e;

  localparam int OFS_W = 4;
  typedef logic signed [OFS_W-1:0] ofs_t;

  // third-order cascade recombination: c1 + d(c2) + d2(c3)
  function automatic ofs_t mash_sum(input logic c1, input logic c2,
                                    input logic c2d, input logic c3,
                                    input logic c3d, input logic c3dd);
    ofs_t s;
    s = ofs_t'(c1) + ofs_t'(c2) - ofs_t'(c2d)
      + ofs_t'(c3) - ofs_t'({c3d, 1'b0}) + ofs_t'(c3dd);
    return s;
  endfunction

endpackage

// File: rtl/fracn_acc.sv
module fracn_acc #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] din,
  input  logic [W-1:0] modv,
  output logic [W-1:0] nxt,
  output logic         carry
);

  logic [W-1:0] acc_q;
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W:0]   sum_m;

  always_comb begin
    base  = clr ? '0 : acc_q;
    sum   = {1'b0, base} + {1'b0, din};
    sum_m = sum - {1'b0, modv};
    carry = (sum >= {1'b0, modv});
    nxt   = carry ? sum_m[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= nxt;
    end
  end

endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
  import fracn_pkg::*;
#(
  parameter int F_W    = 12,
  parameter int STAGES = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           restart,
  input  logic [F_W-1:0] frac,
  input  logic [F_W-1:0] modv,
  output ofs_t           ofs
);

  logic           zero_mode;
  logic           clr;
  logic [F_W-1:0] din [STAGES];
  logic [F_W-1:0] nxt [STAGES];
  logic           cy  [STAGES];

  logic c2d_q, c3d_q, c3dd_q;
  logic c2d_b, c3d_b, c3dd_b;
  logic c2d_d, c3d_d, c3dd_d;

  assign zero_mode = (frac == '0);
  assign clr       = restart | zero_mode;
  assign din[0]    = frac;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g > 0) begin : g_chain
      assign din[g] = nxt[g-1];
    end
    fracn_acc #(.W(F_W)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (step),
      .clr  (clr),
      .din  (din[g]),
      .modv (modv),
      .nxt  (nxt[g]),
      .carry(cy[g])
    );
  end

  always_comb begin
    c2d_b  = clr ? 1'b0 : c2d_q;
    c3d_b  = clr ? 1'b0 : c3d_q;
    c3dd_b = clr ? 1'b0 : c3dd_q;
    c2d_d  = cy[1];
    c3d_d  = cy[2];
    c3dd_d = c3d_b;
    ofs    = zero_mode ? '0 : mash_sum(cy[0], cy[1], c2d_b, cy[2], c3d_b, c3dd_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2d_q  <= 1'b0;
      c3d_q  <= 1'b0;
      c3dd_q <= 1'b0;
    end else if (step) begin
      c2d_q  <= c2d_d;
      c3d_q  <= c3d_d;
      c3dd_q <= c3dd_d;
    end
  end

endmodule

// File: rtl/fracn_split.sv
module fracn_split #(
  parameter int N_W = 12,
  parameter int B_W = 9,
  parameter int A_W = 3
) (
  input  logic signed [N_W+1:0] n_val,
  input  logic                  p_hi,
  output logic [N_W-1:0]        n_ok,
  output logic [B_W-1:0]        b_out,
  output logic [A_W-1:0]        a_out,
  output logic                  err
);

  localparam logic [N_W+1:0] B_LIM = (N_W+2)'((1 << B_W) - 1);

  logic [N_W+1:0] nu;
  logic [N_W+1:0] b_full;
  logic [A_W-1:0] a_full;
  logic           neg;

  always_comb begin
    nu     = n_val;
    neg    = n_val[N_W+1];
    b_full = p_hi ? (nu >> A_W) : (nu >> (A_W - 1));
    a_full = p_hi ? nu[A_W-1:0] : {1'b0, nu[A_W-2:0]};
    err    = neg | (b_full > B_LIM) | (b_full < {{(N_W+2-A_W){1'b0}}, a_full});
    b_out  = err ? '0 : b_full[B_W-1:0];
    a_out  = err ? '0 : a_full;
    n_ok   = err ? '0 : nu[N_W-1:0];
  end

endmodule

// File: rtl/fracn_abcnt.sv
module fracn_abcnt #(
  parameter int B_W = 9,
  parameter int A_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [B_W-1:0] b_ld,
  input  logic [A_W-1:0] a_ld,
  output logic           term,
  output logic           div_pulse,
  output logic           mod_ctl,
  output logic [B_W-1:0] b_q,
  output logic [A_W-1:0] a_q
);

  logic [B_W-1:0] idx_q, idx_d, b_d;
  logic [A_W-1:0] a_d;
  logic           idle, at_end;

  always_comb begin
    idle      = (b_q == '0);
    at_end    = (idx_q == (b_q - 1'b1));
    term      = idle | at_end;
    div_pulse = ~idle & at_end;
    mod_ctl   = ~idle & ({{(B_W-A_W){1'b0}}, a_q} > idx_q);
    if (term) begin
      idx_d = '0;
      b_d   = b_ld;
      a_d   = a_ld;
    end else begin
      idx_d = idx_q + 1'b1;
      b_d   = b_q;
      a_d   = a_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      b_q   <= '0;
      a_q   <= '0;
    end else begin
      idx_q <= idx_d;
      b_q   <= b_d;
      a_q   <= a_d;
    end
  end

endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl
  import fracn_pkg::*;
#(
  parameter int F_W = 12,
  parameter int B_W = 9,
  parameter int A_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [B_W+A_W-1:0]   int_in,
  input  logic [F_W-1:0]       frac_in,
  input  logic [F_W-1:0]       mod_in,
  input  logic                 psel_in,
  output logic                 mod_ctl,
  output logic                 div_pulse,
  output logic [B_W+A_W-1:0]   n_cur,
  output logic [B_W-1:0]       b_cur,
  output logic [A_W-1:0]       a_cur,
  output logic                 ratio_err
);

  localparam int N_W = B_W + A_W;

  // reset: asynchronous assert, synchronous release
  logic rs_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q  <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta_q  <= 1'b1;
      rst_sync_n <= rs_meta_q;
    end
  end

  // shadow and active word banks
  logic [N_W-1:0] sh_int_q, sh_int_d, act_int_q, act_int_d, sel_int;
  logic [F_W-1:0] sh_frac_q, sh_frac_d, act_frac_q, act_frac_d, sel_frac;
  logic [F_W-1:0] sh_mod_q, sh_mod_d, act_mod_q, act_mod_d, sel_mod;
  psel_e          sh_p_q, sh_p_d, act_p_q, act_p_d, sel_p;
  logic           pend_q, pend_d;
  logic [N_W-1:0] n_q, n_d;
  logic           err_q, err_d;

  logic                  cnt_term;
  ofs_t                  ofs;
  logic signed [N_W+1:0] n_sum;
  logic [N_W-1:0]        n_ok;
  logic [B_W-1:0]        b_nx;
  logic [A_W-1:0]        a_nx;
  logic                  err_nx;

  always_comb begin
    pend_d    = load | (pend_q & ~cnt_term);
    sh_int_d  = load ? int_in  : sh_int_q;
    sh_frac_d = load ? frac_in : sh_frac_q;
    sh_mod_d  = load ? mod_in  : sh_mod_q;
    sh_p_d    = load ? psel_e'(psel_in) : sh_p_q;

    sel_int  = pend_q ? sh_int_q  : act_int_q;
    sel_frac = pend_q ? sh_frac_q : act_frac_q;
    sel_mod  = pend_q ? sh_mod_q  : act_mod_q;
    sel_p    = pend_q ? sh_p_q    : act_p_q;

    if (cnt_term) begin
      act_int_d  = sel_int;
      act_frac_d = sel_frac;
      act_mod_d  = sel_mod;
      act_p_d    = sel_p;
      n_d        = n_ok;
      err_d      = err_nx;
    end else begin
      act_int_d  = act_int_q;
      act_frac_d = act_frac_q;
      act_mod_d  = act_mod_q;
      act_p_d    = act_p_q;
      n_d        = n_q;
      err_d      = err_q;
    end

    n_sum = $signed({2'b00, sel_int}) + $signed({{(N_W+2-OFS_W){ofs[OFS_W-1]}}, ofs});
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q     <= 1'b0;
      sh_int_q   <= '0;
      sh_frac_q  <= '0;
      sh_mod_q   <= '0;
      sh_p_q     <= PS_LO;
      act_int_q  <= '0;
      act_frac_q <= '0;
      act_mod_q  <= '0;
      act_p_q    <= PS_LO;
      n_q        <= '0;
      err_q      <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      sh_int_q   <= sh_int_d;
      sh_frac_q  <= sh_frac_d;
      sh_mod_q   <= sh_mod_d;
      sh_p_q     <= sh_p_d;
      act_int_q  <= act_int_d;
      act_frac_q <= act_frac_d;
      act_mod_q  <= act_mod_d;
      act_p_q    <= act_p_d;
      n_q        <= n_d;
      err_q      <= err_d;
    end
  end

  fracn_mash #(.F_W(F_W), .STAGES(3)) u_mash (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step   (cnt_term),
    .restart(pend_q),
    .frac   (sel_frac),
    .modv   (sel_mod),
    .ofs    (ofs)
  );

  fracn_split #(.N_W(N_W), .B_W(B_W), .A_W(A_W)) u_split (
    .n_val(n_sum),
    .p_hi (sel_p == PS_HI),
    .n_ok (n_ok),
    .b_out(b_nx),
    .a_out(a_nx),
    .err  (err_nx)
  );

  fracn_abcnt #(.B_W(B_W), .A_W(A_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .b_ld     (b_nx),
    .a_ld     (a_nx),
    .term     (cnt_term),
    .div_pulse(div_pulse),
    .mod_ctl  (mod_ctl),
    .b_q      (b_cur),
    .a_q      (a_cur)
  );

  assign n_cur     = n_q;
  assign ratio_err = err_q;

endmodule

// File: rtl/fracn_divctl_chk.sv
module fracn_divctl_chk #(
  parameter int B_W = 9,
  parameter int A_W = 3,
  parameter int N_W = 12
) (
  input logic           clk,
  input logic           rst_sync_n,
  input logic           load,
  input logic           pend_q,
  input logic           cnt_term,
  input logic           mod_ctl,
  input logic           div_pulse,
  input logic [N_W-1:0] n_cur,
  input logic [B_W-1:0] b_cur,
  input logic [A_W-1:0] a_cur,
  input logic           ratio_err,
  input logic [N_W-1:0] act_int_q,
  input logic           act_hi
);

  localparam int F_CHK = 12;

  AST_LOAD_PENDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> pend_q) else $error("load not pending"); // R2

  AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cnt_term |=> ($stable(n_cur) && $stable(b_cur) && $stable(a_cur))) else $error("counts moved mid-cycle"); // R2

  AST_PULSE_NEEDS_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_pulse |-> (b_cur != '0)) else $error("pulse while idle"); // R3

  AST_SPLIT_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (b_cur != '0) |-> (n_cur == ((N_W'(b_cur) << (act_hi ? A_W : A_W - 1)) + N_W'(a_cur)))) else $error("split mismatch"); // R4

  AST_MODCTL_PREFIX: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mod_ctl) |-> $past(cnt_term)) else $error("mod_ctl rose mid-cycle"); // R5

  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (b_cur != '0) |-> ((({1'b0, n_cur} + (N_W+1)'(3)) >= {1'b0, act_int_q}) &&
                       ({1'b0, n_cur} <= ({1'b0, act_int_q} + (N_W+1)'(4))))) else $error("offset range"); // R6

  AST_A_LE_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (b_cur != '0) |-> (N_W'(a_cur) <= N_W'(b_cur))) else $error("swallow above main"); // R9

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ratio_err |-> ((b_cur == '0) && !div_pulse && !mod_ctl)) else $error("error not idle"); // R9

endmodule

bind fracn_divctl fracn_divctl_chk #(.B_W(B_W), .A_W(A_W), .N_W(B_W + A_W)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .load      (load),
  .pend_q    (pend_q),
  .cnt_term  (cnt_term),
  .mod_ctl   (mod_ctl),
  .div_pulse (div_pulse),
  .n_cur     (n_cur),
  .b_cur     (b_cur),
  .a_cur     (a_cur),
  .ratio_err (ratio_err),
  .act_int_q (act_int_q),
  .act_hi    (act_p_q == fracn_pkg::PS_HI)
);

// File: tb/fracn_divctl_test.sv
`timescale 1ns/1ps
module fracn_divctl_test;

  localparam int F_W = 12;
  localparam int B_W = 9;
  localparam int A_W = 3;
  localparam int N_W = B_W + A_W;
  localparam int NV  = 7;

  // stimulus table: integer, fraction, modulus, prescaler select (1 = 8/9)
  localparam int V_INT  [NV] = '{100, 57, 200, 83, 40, 4095, 150};
  localparam int V_FRAC [NV] = '{1,   5,  7,   0,  2,  0,    99};
  localparam int V_MOD  [NV] = '{4,   13, 10,  9,  3,  2,    100};
  localparam int V_PS   [NV] = '{1,   0,  1,   0,  0,  1,    0};

  logic           clk, rst_n, load, psel_in;
  logic [N_W-1:0] int_in;
  logic [F_W-1:0] frac_in, mod_in;
  logic           mod_ctl, div_pulse, ratio_err;
  logic [N_W-1:0] n_cur;
  logic [B_W-1:0] b_cur;
  logic [A_W-1:0] a_cur;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  fracn_divctl #(.F_W(F_W), .B_W(B_W), .A_W(A_W)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .int_in(int_in), .frac_in(frac_in),
    .mod_in(mod_in), .psel_in(psel_in), .mod_ctl(mod_ctl), .div_pulse(div_pulse),
    .n_cur(n_cur), .b_cur(b_cur), .a_cur(a_cur), .ratio_err(ratio_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input int i_int, input int i_frac, input int i_mod, input int i_ps);
    @(negedge clk);
    int_in  = i_int[N_W-1:0];
    frac_in = i_frac[F_W-1:0];
    mod_in  = i_mod[F_W-1:0];
    psel_in = i_ps[0];
    load    = 1'b1;
    @(negedge clk);
    load = 1'b0;
    if (b_cur == '0) begin
      @(negedge clk);
    end else begin
      while (!div_pulse) @(negedge clk);
      @(negedge clk);
    end
  endtask

  // entered at the first falling edge of the first divide cycle of a config
  task automatic measure(input int i_int, input int i_frac, input int i_mod, input int i_ps);
    int     p;
    longint sum;
    longint expv;
    p   = (i_ps != 0) ? 8 : 4;
    sum = 0;
    for (int k = 0; k < 8 * i_mod; k++) begin
      int n, b, a, rf, clks, off;
      bit mc_ok;
      n = int'(n_cur); b = int'(b_cur); a = int'(a_cur);
      rf = 0; clks = 0; mc_ok = 1'b1;
      forever begin
        if (mod_ctl != (clks < a)) mc_ok = 1'b0;
        rf += mod_ctl ? p + 1 : p;
        clks++;
        if (div_pulse || clks > 600) break;
        @(negedge clk);
      end
      @(negedge clk);
      chk(rf == n, "R3 input periods", rf, n);
      chk(clks == b, "R3 cycle length", clks, b);
      chk(b == n / p && a == n % p, "R4 split", b * 16 + a, (n / p) * 16 + n % p);
      chk(mc_ok, "R5 swallow prefix", mc_ok, 1);
      off = n - i_int;
      chk(off >= -3 && off <= 4, "R6 offset", off, 0);
      if (i_frac == 0) chk(n == i_int, "R8 integer exact", n, i_int);
      sum += n;
    end
    expv = 8 * (longint'(i_mod) * i_int + i_frac);
    chk(sum >= expv - 1 && sum <= expv + 1, "R7 summed ratio", sum, expv);
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0; psel_in = 1'b0;
    int_in = '0; frac_in = '0; mod_in = '0;
    repeat (4) @(negedge clk);
    chk(n_cur == 0 && b_cur == 0 && a_cur == 0 && !mod_ctl && !div_pulse && !ratio_err,
        "R1 in reset", {n_cur, b_cur, a_cur}, 0);
    rst_n = 1'b1;
    begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (div_pulse || mod_ctl || ratio_err || n_cur != 0 || b_cur != 0) quiet = 1'b0;
      end
      chk(quiet, "R1 idle after reset", quiet, 1);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      apply_cfg(V_INT[v], V_FRAC[v], V_MOD[v], V_PS[v]);
      measure(V_INT[v], V_FRAC[v], V_MOD[v], V_PS[v]);
    end

    // R2: load mid-cycle only takes effect at the boundary
    apply_cfg(100, 0, 2, 1);
    chk(n_cur == 100, "R2 start value", n_cur, 100);
    repeat (3) @(negedge clk);
    int_in = 12'd60; frac_in = '0; mod_in = 12'd2; psel_in = 1'b1; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    begin
      bit held;
      held = 1'b1;
      while (!div_pulse) begin
        if (n_cur != 100 || b_cur != 12 || a_cur != 4) held = 1'b0;
        @(negedge clk);
      end
      if (n_cur != 100) held = 1'b0;
      chk(held, "R2 held until boundary", n_cur, 100);
    end
    @(negedge clk);
    chk(n_cur == 60 && b_cur == 7 && a_cur == 4, "R2 new value after boundary",
        {n_cur, b_cur, a_cur}, {12'd60, 9'd7, 3'd4});

    // R9: ratio too small for the 8/9 pair (main 0 < swallow 2)
    apply_cfg(2, 0, 2, 1);
    chk(ratio_err && b_cur == 0, "R9 main below swallow", {ratio_err, b_cur}, {1'b1, 9'd0});
    begin
      bit none;
      none = 1'b1;
      for (int i = 0; i < 20; i++) begin
        if (div_pulse || mod_ctl) none = 1'b0;
        @(negedge clk);
      end
      chk(none, "R9 idle while in error", none, 1);
    end

    // R9: main count above 511 with the 4/5 pair
    apply_cfg(4095, 0, 2, 0);
    chk(ratio_err && b_cur == 0, "R9 main count overflow", ratio_err, 1);

    // R9: ratio zero idles without error
    apply_cfg(0, 0, 2, 0);
    chk(!ratio_err && b_cur == 0 && !div_pulse, "R9 zero ratio idle", ratio_err, 0);

    // recover with a valid setting after an error
    apply_cfg(41, 1, 2, 0);
    measure(41, 1, 2, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

endmodule